// File: doc/BRIEF.md
# Memory Block Compare Engine

The engine walks two regions of memory in lockstep and compares them one element at a time. A single start pulse loads an element count, a source pointer, a destination pointer, a walk direction and an element width. The engine then reads the source element and the destination element through one synchronous read port. It compares the two as unsigned values, moves both pointers one place and lowers the count. It stops at the first difference or when the count reaches zero.

When the walk ends, a one-cycle done pulse marks the result. A two-bit condition code states whether the destination element was greater than, less than or equal to the source element. The residual count and both pointers stay on the outputs until the next start. The pointers are flat addresses: byte addresses with 8-bit elements in byte mode, and word addresses with 16-bit elements in word mode. In both modes a step moves a pointer by exactly one.

Control is a five-state machine:
- IDLE waits for start. It goes to FINISH when the loaded count is zero and to RD_SRC otherwise.
- RD_SRC issues the source read and always goes to RD_DST.
- RD_DST issues the destination read, captures the returned source element and always goes to CMP.
- CMP compares the captured source element with the returned destination element. On a difference it goes to FINISH. On a match it steps the pointers and count. It then goes to FINISH if that was the last element and back to RD_SRC otherwise.
- FINISH raises done and returns to IDLE.

Top module: `blkcmp_engine`

## Requirements
- R1: After reset the outputs are as follows: busy_o is 0, done_o is 0, cc_o is 2'b00 (equal), and count_o, src_o and dst_o are zero.
- R2: start_i is sampled only in IDLE. busy_o is 1 from the cycle after start until done. A start pulse while busy_o is 1 is ignored and has no effect on the result.
- R3: With dir_down_i = 0, src_o and dst_o each increase by one after every matching comparison.
- R4: With dir_down_i = 1, src_o and dst_o each decrease by one after every matching comparison.
- R5: If all compared elements match, the run ends with cc_o = 2'b00 and count_o = 0. src_o and dst_o then address the first locations that were not compared.
- R6: On the first mismatch where the destination element is the larger unsigned value, cc_o = 2'b10. count_o then includes the differing element, and src_o and dst_o address the differing elements.
- R7: On the first mismatch where the destination element is the smaller unsigned value, cc_o = 2'b01. Count and pointers follow the same rule as in R6.
- R8: With byte_mode_i = 1, only mem_rdata_i[7:0] takes part in the comparison. With byte_mode_i = 0, all 16 bits take part.
- R9: A start with count_i = 0 gives done one cycle later, with cc_o = 2'b00, no memory reads, count_o = 0 and the pointers unchanged.
- R10: Each element costs exactly two reads, the source read followed on the next cycle by the destination read, and three cycles in total. done_o is a one-cycle pulse, 1 + 3*k cycles after the start edge, where k is the number of elements read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled in IDLE |
| count_i | input | 16 | Number of elements to compare |
| src_i | input | 16 | Source start address |
| dst_i | input | 16 | Destination start address |
| dir_down_i | input | 1 | 0 = ascending walk, 1 = descending walk |
| byte_mode_i | input | 1 | 1 = 8-bit elements, 0 = 16-bit elements |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| cc_o | output | 2 | 00 equal, 01 destination less, 10 destination greater |
| count_o | output | 16 | Residual element count |
| src_o | output | 16 | Final source pointer |
| dst_o | output | 16 | Final destination pointer |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Read data, valid one cycle after the strobe |

## Verification
If the machine enters a wrong state or skips a transition, the error reaches the ports at once. The number of read strobes changes, and the done pulse moves away from its slot of 1 + 3*k cycles; both are counted for every run. A pointer or count that steps wrongly, or a mismatch that is reported one step late, shows up in the final count_o, src_o and dst_o when done fires. A wrong choice of element width or comparison order shows up in cc_o for the same run.

// File: rtl/blkcmp_pkg.sv
package blkcmp_pkg;
    typedef enum logic [1:0] {
        CC_EQ = 2'b00,
        CC_LT = 2'b01,
        CC_GT = 2'b10
    } cc_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_SRC,
        S_RD_DST,
        S_CMP,
        S_FINISH
    } state_e;
endpackage

// File: rtl/blkcmp_ptr_step.sv
module blkcmp_ptr_step #(
    parameter int AW = 16
) (
    input  logic [AW-1:0] ptr_i,
    input  logic          down_i,
    output logic [AW-1:0] ptr_o
);
    localparam logic [AW-1:0] ONE = AW'(1);

    always_comb begin
        ptr_o = down_i ? (ptr_i - ONE) : (ptr_i + ONE);
    end
endmodule

// File: rtl/blkcmp_elem_cmp.sv
module blkcmp_elem_cmp
    import blkcmp_pkg::*;
#(
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic [DW-1:0] src_i,
    input  logic [DW-1:0] dst_i,
    input  logic          byte_mode_i,
    output cc_e           rel_o
);
    logic [DW-1:0] s_ext, d_ext;

    always_comb begin
        if (byte_mode_i) begin
            s_ext = {{(DW-BW){1'b0}}, src_i[BW-1:0]};
            d_ext = {{(DW-BW){1'b0}}, dst_i[BW-1:0]};
        end else begin
            s_ext = src_i;
            d_ext = dst_i;
        end
        if (d_ext > s_ext)      rel_o = CC_GT;
        else if (d_ext < s_ext) rel_o = CC_LT;
        else                    rel_o = CC_EQ;
    end
endmodule

// File: rtl/blkcmp_engine.sv
module blkcmp_engine
    import blkcmp_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16,
    parameter int DW = 16,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [CW-1:0] count_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic          dir_down_i,
    input  logic          byte_mode_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [1:0]    cc_o,
    output logic [CW-1:0] count_o,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic          mem_rd_o,
    output logic [AW-1:0] mem_addr_o,
    input  logic [DW-1:0] mem_rdata_i
);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    state_e        state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] src_q, dst_q, src_nx, dst_nx;
    logic [DW-1:0] sdat_q;
    logic          down_q, bmode_q;
    cc_e           cc_q, rel;

    blkcmp_ptr_step #(.AW(AW)) u_src_step (.ptr_i(src_q), .down_i(down_q), .ptr_o(src_nx));
    blkcmp_ptr_step #(.AW(AW)) u_dst_step (.ptr_i(dst_q), .down_i(down_q), .ptr_o(dst_nx));

    blkcmp_elem_cmp #(.DW(DW), .BW(BW)) u_cmp (
        .src_i      (sdat_q),
        .dst_i      (mem_rdata_i),
        .byte_mode_i(bmode_q),
        .rel_o      (rel)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = (count_i == '0) ? S_FINISH : S_RD_SRC;
            S_RD_SRC: state_d = S_RD_DST;
            S_RD_DST: state_d = S_CMP;
            S_CMP:    state_d = (rel != CC_EQ || cnt_q == CNT_ONE) ? S_FINISH : S_RD_SRC;
            S_FINISH: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            src_q   <= '0;
            dst_q   <= '0;
            sdat_q  <= '0;
            down_q  <= 1'b0;
            bmode_q <= 1'b0;
            cc_q    <= CC_EQ;
        end else begin
            unique case (state_q)
                S_IDLE: if (start_i) begin
                    cnt_q   <= count_i;
                    src_q   <= src_i;
                    dst_q   <= dst_i;
                    down_q  <= dir_down_i;
                    bmode_q <= byte_mode_i;
                    cc_q    <= CC_EQ;
                end
                S_RD_DST: sdat_q <= mem_rdata_i;
                S_CMP: begin
                    if (rel != CC_EQ) begin
                        cc_q <= rel;
                    end else begin
                        cnt_q <= cnt_q - CNT_ONE;
                        src_q <= src_nx;
                        dst_q <= dst_nx;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != S_IDLE);
        done_o     = (state_q == S_FINISH);
        mem_rd_o   = 1'b0;
        mem_addr_o = src_q;
        unique case (state_q)
            S_RD_SRC: begin mem_rd_o = 1'b1; mem_addr_o = src_q; end
            S_RD_DST: begin mem_rd_o = 1'b1; mem_addr_o = dst_q; end
            default:  ;
        endcase
        cc_o    = cc_q;
        count_o = cnt_q;
        src_o   = src_q;
        dst_o   = dst_q;
    end

    // assertions
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!done_o && !mem_rd_o));
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && state_q != S_FINISH && start_i) |=> (busy_o && $stable(down_q) && $stable(bmode_q)));
    p_asc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CMP && rel == CC_EQ && !down_q) |=> (src_q == $past(src_q) + AW'(1) && dst_q == $past(dst_q) + AW'(1)));
    p_desc_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CMP && rel == CC_EQ && down_q) |=> (src_q == $past(src_q) - AW'(1) && dst_q == $past(dst_q) - AW'(1)));
    p_eq_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cc_o == CC_EQ) |-> count_o == '0);
    p_mismatch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CMP && rel != CC_EQ) |=> (done_o && $stable(cnt_q) && $stable(src_q) && cc_o != CC_EQ));
    p_zero_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && start_i && count_i == '0) |=> (done_o && !mem_rd_o));
    p_read_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_o && mem_addr_o == src_q && state_q == S_RD_SRC) |=> (mem_rd_o && mem_addr_o == dst_q));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: tb/tb_blkcmp_engine.sv
`timescale 1ns/1ps
module tb_blkcmp_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] count_i = '0, src_i = '0, dst_i = '0;
    logic        dir_down_i = 1'b0, byte_mode_i = 1'b0;
    logic        busy_o, done_o, mem_rd_o;
    logic [1:0]  cc_o;
    logic [15:0] count_o, src_o, dst_o, mem_addr_o;
    logic [15:0] mem_rdata_i = '0;

    logic [15:0] mem [256];

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int rd_cnt = 0;
    bit prev_done = 1'b0;

    typedef struct {
        logic [1:0]  cc;
        logic [15:0] cnt, src, dst;
        int          done_cyc, reads;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    exp_t e;

    always #2.5 clk = ~clk;

    blkcmp_engine dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .count_i(count_i),
        .src_i(src_i), .dst_i(dst_i), .dir_down_i(dir_down_i),
        .byte_mode_i(byte_mode_i), .busy_o(busy_o), .done_o(done_o),
        .cc_o(cc_o), .count_o(count_o), .src_o(src_o), .dst_o(dst_o),
        .mem_rd_o(mem_rd_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_rd_o) begin
            rd_cnt      <= rd_cnt + 1;
            mem_rdata_i <= mem[mem_addr_o[7:0]];
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected result on each done pulse
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_done && done_o) chk("R10 done pulse width", 1, 0);
            prev_done = done_o;
            if (done_o) begin
                if (sb_q.size() == 0) begin
                    chk("R2 unexpected done", 1, 0);
                end else begin
                    e = sb_q.pop_front();
                    chk({e.tag, " cc"},      cc_o,    e.cc);
                    chk({e.tag, " count"},   count_o, e.cnt);
                    chk({e.tag, " src"},     src_o,   e.src);
                    chk({e.tag, " dst"},     dst_o,   e.dst);
                    chk({e.tag, " R10 latency"}, cyc, e.done_cyc);
                    chk({e.tag, " R10 reads"},   rd_cnt, e.reads);
                end
            end
        end
    end

    // driver: computes expected result from the requirements, pushes it, starts the run
    task automatic launch(input logic [15:0] n, input logic [15:0] s, input logic [15:0] d,
                          input logic down, input logic bmode, input string tag);
        exp_t x;
        logic [15:0] c = n, ps = s, pd = d, a, b;
        int steps = 0;
        x.cc = 2'b00;
        while (c != 0) begin
            a = mem[ps[7:0]];
            b = mem[pd[7:0]];
            if (bmode) begin a = {8'h00, a[7:0]}; b = {8'h00, b[7:0]}; end
            steps++;
            if (a != b) begin
                x.cc = (b > a) ? 2'b10 : 2'b01;
                break;
            end
            c--;
            ps = down ? ps - 16'd1 : ps + 16'd1;
            pd = down ? pd - 16'd1 : pd + 16'd1;
        end
        do @(negedge clk); while (busy_o);
        x.cnt = c; x.src = ps; x.dst = pd; x.tag = tag;
        x.done_cyc = cyc + 1 + 3 * steps;
        x.reads = rd_cnt + 2 * steps;
        sb_q.push_back(x);
        count_i = n; src_i = s; dst_i = d; dir_down_i = down; byte_mode_i = bmode;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk({tag, " R2 busy"}, busy_o, 1);
    endtask

    task automatic drain();
        while (sb_q.size() != 0 || busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = {8'(i * 7 + 3), 8'(i * 13 + 1)};
        for (int i = 0; i < 16; i++) begin
            mem[8'h40 + i] = mem[8'h10 + i];
            mem[8'hC0 + i] = mem[8'h80 + i];
            mem[8'hE0 + i] = mem[8'hA0 + i];
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 cc", cc_o, 0);
        chk("R1 count", count_o, 0);
        chk("R1 src", src_o, 0);
        chk("R1 dst", dst_o, 0);
        rst_n = 1'b1;
        @(negedge clk);

        launch(16'd8, 16'h0010, 16'h0040, 1'b0, 1'b0, "R3 R5 ascending equal");
        launch(16'd8, 16'h001F, 16'h004F, 1'b1, 1'b0, "R4 R5 descending equal");
        launch(16'd1, 16'h0012, 16'h0042, 1'b0, 1'b0, "R5 single element");
        drain();
        mem[8'h43] = mem[8'h13] + 16'h0100;
        launch(16'd8, 16'h0010, 16'h0040, 1'b0, 1'b0, "R6 greater ascending");
        drain();
        mem[8'h4C] = mem[8'h1C] - 16'h0001;
        launch(16'd8, 16'h001F, 16'h004F, 1'b1, 1'b0, "R7 less descending");
        drain();
        mem[8'hC2] = mem[8'h82] ^ 16'hFF00;
        launch(16'd6, 16'h0080, 16'h00C0, 1'b0, 1'b1, "R8 byte mode ignores high byte");
        launch(16'd6, 16'h0080, 16'h00C0, 1'b0, 1'b0, "R8 word mode sees high byte");
        drain();
        mem[8'hA1] = 16'h7FFF;
        mem[8'hE1] = 16'h8000;
        launch(16'd4, 16'h00A0, 16'h00E0, 1'b0, 1'b0, "R6 unsigned greater");
        drain();
        mem[8'hA2] = 16'h0080; mem[8'hE2] = 16'h0070; mem[8'hA1] = 16'h8000;
        launch(16'd4, 16'h00A0, 16'h00E0, 1'b0, 1'b1, "R7 byte unsigned less");
        launch(16'd0, 16'h0033, 16'h0077, 1'b1, 1'b0, "R9 zero count");
        // R2: start pulse during a run must be ignored
        launch(16'd4, 16'h0010, 16'h0040, 1'b0, 1'b0, "R2 start while busy");
        count_i = 16'd0; src_i = 16'h0099; dst_i = 16'h0099; dir_down_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        drain();
        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule